// File: doc/BRIEF.md
# Flash Program and Page-Erase Sequencer

This block is a register-mapped controller placed in front of an embedded flash array. Software talks to it through a small register port: a key register, a control register, a status register and an erase-address register. A separate data-write port carries writes aimed at flash locations. The block sequences single-unit program operations and whole-page erases onto a simple array port made of an address, write data, read data, a program strobe and an erase strobe.

After reset the control register is locked. A two-word key sequence opens it. Only then can software select program mode or erase mode and start operations. Each operation keeps a busy flag set for a latency, in clock cycles, given by a parameter. At the end of that latency the block raises one strobe cycle toward the array and sets an end-of-operation flag. Two conditions stop an operation with an error flag: a target page marked write-protected, and a program into a location that is not erased. Every status flag is cleared by writing a one to it.

Top module: `flpe_ctrl`

## Requirements
- R1: After reset the control register reads 0x80 (bit 7 = locked, bit 0 = program enable, bit 1 = erase enable, all others zero) and the status register reads 0.
- R2: Writing KEY_A and then KEY_B as the next two key-register writes unlocks the block, after which the control register reads bit 7 = 0. Control writes made while locked are ignored.
- R3: A wrong value at either key step kills the key logic until the next reset. A correct sequence written after that leaves the block locked.
- R4: A control write with bit 7 set relocks the block and clears both mode bits. A fresh two-key sequence is then needed before control writes take effect again.
- R5: The busy flag (status bit 0) stays set for exactly PROG_CYCLES cycles on a program and ERASE_CYCLES cycles on an erase. The single array strobe comes in the last busy cycle.
- R6: End-of-operation (status bit 1) is set when an operation completes. Writing a one to bit 1, 2 or 3 of the status register clears that flag, and writing zeros leaves the flags unchanged.
- R7: With program enable set, a data-port write to unit address A launches a program operation. On completion the program strobe carries A and the written data.
- R8: A data-port write is ignored when program enable is clear or when the block is locked: no strobe and no busy.
- R9: An erase starts only after three steps in this order: set erase enable (control bit 1), write the address register (offset 3), then write control with bit 2 (start) and bit 1 set. A start without an address loaded since erase enable was set is ignored. The erase strobe carries the page base address.
- R10: A program or an erase aimed at a page whose bit in wp_mask_i is set sets write-protect error (status bit 3), produces no strobe and leaves the array unchanged.
- R11: A nonzero program to a unit whose current content is not all ones sets program error (status bit 2) and is skipped. Programming zero is always performed.
- R12: While busy is set, control-register writes and data-port writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wp_mask_i | input | NUM_PAGES | Per-page write-protect bits, 1 = protected |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 key, 1 control, 2 status, 3 erase address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the register selected by reg_addr_i |
| fw_we_i | input | 1 | Flash data write strobe |
| fw_addr_i | input | AW | Flash unit address of the data write |
| fw_data_i | input | DW | Data of the flash data write |
| fl_addr_o | output | AW | Array address (operation address while busy, else fw_addr_i) |
| fl_wdata_o | output | DW | Array program data |
| fl_rdata_i | input | DW | Array content at fl_addr_o |
| fl_prog_o | output | 1 | One-cycle program strobe |
| fl_erase_o | output | 1 | One-cycle page-erase strobe |

## Verification
The assertions assume that wp_mask_i is stable while an operation runs. They also assume that fl_rdata_i returns, in the same cycle, the array content at fl_addr_o. The bench holds the protect mask constant after reset and models the array as a combinational read of its own memory. That memory is updated only on the strobes. Stimulus changes at the falling edge and lasts one cycle, so every register or data write is seen at exactly one rising edge.

// File: rtl/flpe_pkg.sv
package flpe_pkg;
  localparam logic [1:0] REG_KEY  = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_ADDR = 2'd3;

  localparam int CB_PROG  = 0;
  localparam int CB_ERASE = 1;
  localparam int CB_START = 2;
  localparam int CB_LOCK  = 7;

  localparam int SB_BUSY  = 0;
  localparam int SB_EOP   = 1;
  localparam int SB_PERR  = 2;
  localparam int SB_WPERR = 3;

  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN, KS_DEAD} key_state_e;
  typedef enum logic {OP_PROG, OP_ERASE} op_kind_e;
endpackage

// File: rtl/flpe_key_lock.sv
module flpe_key_lock
  import flpe_pkg::*;
#(
  parameter logic [31:0] KEY_A = 32'hC0DE_1A2B,
  parameter logic [31:0] KEY_B = 32'h5EED_F00D
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_we_i,
  input  logic [31:0] key_data_i,
  input  logic        relock_i,
  output logic        unlocked_o
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      KS_LOCKED: if (key_we_i) st_d = (key_data_i == KEY_A) ? KS_HALF : KS_DEAD;
      KS_HALF:   if (key_we_i) st_d = (key_data_i == KEY_B) ? KS_OPEN : KS_DEAD;
      KS_OPEN:   if (relock_i) st_d = KS_LOCKED;
      default:   st_d = KS_DEAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= KS_LOCKED;
    else         st_q <= st_d;

  assign unlocked_o = (st_q == KS_OPEN);

  p_dead_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == KS_DEAD) |=> (st_q == KS_DEAD));
  p_relock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (relock_i && unlocked_o) |=> !unlocked_o);
  p_open_via_half_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> ($past(st_q) == KS_HALF));
endmodule

// File: rtl/flpe_wp_check.sv
module flpe_wp_check #(
  parameter int NUM_PAGES = 8,
  parameter int PAGE_BITS = 4,
  parameter int AW        = 7
) (
  input  logic [AW-1:0]        addr_i,
  input  logic [NUM_PAGES-1:0] wp_mask_i,
  output logic                 prot_o,
  output logic [AW-1:0]        page_base_o
);
  localparam int PGW = AW - PAGE_BITS;
  logic [PGW-1:0] page;

  assign page        = addr_i[AW-1:PAGE_BITS];
  assign prot_o      = wp_mask_i[page];
  assign page_base_o = {page, {PAGE_BITS{1'b0}}};
endmodule

// File: rtl/flpe_op_timer.sv
module flpe_op_timer
  import flpe_pkg::*;
#(
  parameter int PROG_CYCLES  = 5,
  parameter int ERASE_CYCLES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_prog_i,
  input  logic start_erase_i,
  output logic busy_o,
  output logic done_prog_o,
  output logic done_erase_o
);
  localparam int MAXL = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  op_kind_e      kind_q;
  logic          last;

  assign last = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= OP_PROG;
    end else if (!busy_q && start_prog_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(PROG_CYCLES - 1);
      kind_q <= OP_PROG;
    end else if (!busy_q && start_erase_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(ERASE_CYCLES - 1);
      kind_q <= OP_ERASE;
    end else if (last) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o       = busy_q;
  assign done_prog_o  = last && (kind_q == OP_PROG);
  assign done_erase_o = last && (kind_q == OP_ERASE);

  p_start_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog_i || start_erase_i) |-> !busy_q);
  p_busy_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);
  p_done_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_prog_o || done_erase_o) |=> !busy_q);
endmodule

// File: rtl/flpe_ctrl.sv
module flpe_ctrl
  import flpe_pkg::*;
#(
  parameter int          WRITE_BYTES  = 2,
  parameter int          NUM_PAGES    = 8,
  parameter int          PAGE_UNITS   = 16,
  parameter int          PROG_CYCLES  = 5,
  parameter int          ERASE_CYCLES = 12,
  parameter logic [31:0] KEY_A        = 32'hC0DE_1A2B,
  parameter logic [31:0] KEY_B        = 32'h5EED_F00D,
  localparam int         DW           = 8 * WRITE_BYTES,
  localparam int         PAGE_BITS    = $clog2(PAGE_UNITS),
  localparam int         AW           = $clog2(NUM_PAGES) + PAGE_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PAGES-1:0] wp_mask_i,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic                 fw_we_i,
  input  logic [AW-1:0]        fw_addr_i,
  input  logic [DW-1:0]        fw_data_i,
  output logic [AW-1:0]        fl_addr_o,
  output logic [DW-1:0]        fl_wdata_o,
  input  logic [DW-1:0]        fl_rdata_i,
  output logic                 fl_prog_o,
  output logic                 fl_erase_o
);
  logic unlocked, busy, done_prog, done_erase;
  logic prog_en_q, erase_en_q, armed_q;
  logic eop_q, perr_q, wperr_q;
  logic [AW-1:0] addr_q, op_addr_q;
  logic [DW-1:0] op_data_q;

  logic ctrl_we, stat_we, addr_we, key_we, can_cfg, relock;
  logic erase_go, prog_try, fw_prot, er_prot, not_erased;
  logic start_prog, start_erase;
  logic [AW-1:0] fw_base_unused, er_base;

  assign key_we  = reg_we_i && (reg_addr_i == REG_KEY);
  assign ctrl_we = reg_we_i && (reg_addr_i == REG_CTRL);
  assign stat_we = reg_we_i && (reg_addr_i == REG_STAT);
  assign addr_we = reg_we_i && (reg_addr_i == REG_ADDR);
  assign can_cfg = unlocked && !busy;
  assign relock  = ctrl_we && can_cfg && reg_wdata_i[CB_LOCK];

  flpe_key_lock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk_i, .rst_ni, .key_we_i(key_we), .key_data_i(reg_wdata_i),
    .relock_i(relock), .unlocked_o(unlocked)
  );

  flpe_wp_check #(.NUM_PAGES(NUM_PAGES), .PAGE_BITS(PAGE_BITS), .AW(AW)) u_wp_fw (
    .addr_i(fw_addr_i), .wp_mask_i, .prot_o(fw_prot), .page_base_o(fw_base_unused)
  );

  flpe_wp_check #(.NUM_PAGES(NUM_PAGES), .PAGE_BITS(PAGE_BITS), .AW(AW)) u_wp_er (
    .addr_i(addr_q), .wp_mask_i, .prot_o(er_prot), .page_base_o(er_base)
  );

  // start only honoured once erase mode and an address were set in earlier writes
  assign erase_go = ctrl_we && can_cfg && !reg_wdata_i[CB_LOCK] && reg_wdata_i[CB_START]
                  && reg_wdata_i[CB_ERASE] && erase_en_q && armed_q;
  assign prog_try   = fw_we_i && unlocked && !busy && prog_en_q;
  assign not_erased = (fl_rdata_i != {DW{1'b1}}) && (fw_data_i != '0);
  assign start_prog  = prog_try && !fw_prot && !not_erased;
  assign start_erase = erase_go && !er_prot;

  flpe_op_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .start_prog_i(start_prog), .start_erase_i(start_erase),
    .busy_o(busy), .done_prog_o(done_prog), .done_erase_o(done_erase)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_en_q  <= 1'b0;
      erase_en_q <= 1'b0;
      armed_q    <= 1'b0;
      addr_q     <= '0;
    end else begin
      if (ctrl_we && can_cfg) begin
        if (reg_wdata_i[CB_LOCK]) begin
          prog_en_q  <= 1'b0;
          erase_en_q <= 1'b0;
          armed_q    <= 1'b0;
        end else begin
          prog_en_q  <= reg_wdata_i[CB_PROG];
          erase_en_q <= reg_wdata_i[CB_ERASE];
          if (!reg_wdata_i[CB_ERASE] || erase_go) armed_q <= 1'b0;
        end
      end
      if (addr_we && can_cfg) begin
        addr_q  <= reg_wdata_i[AW-1:0];
        armed_q <= erase_en_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_addr_q <= '0;
      op_data_q <= '0;
    end else if (start_prog) begin
      op_addr_q <= fw_addr_i;
      op_data_q <= fw_data_i;
    end else if (start_erase) begin
      op_addr_q <= er_base;
      op_data_q <= {DW{1'b1}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eop_q   <= 1'b0;
      perr_q  <= 1'b0;
      wperr_q <= 1'b0;
    end else begin
      eop_q   <= (eop_q & ~(stat_we & reg_wdata_i[SB_EOP])) | done_prog | done_erase;
      perr_q  <= (perr_q & ~(stat_we & reg_wdata_i[SB_PERR])) | (prog_try & !fw_prot & not_erased);
      wperr_q <= (wperr_q & ~(stat_we & reg_wdata_i[SB_WPERR]))
               | (prog_try & fw_prot) | (erase_go & er_prot);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CTRL: begin
        reg_rdata_o[CB_LOCK]  = !unlocked;
        reg_rdata_o[CB_PROG]  = prog_en_q;
        reg_rdata_o[CB_ERASE] = erase_en_q;
      end
      REG_STAT: begin
        reg_rdata_o[SB_BUSY]  = busy;
        reg_rdata_o[SB_EOP]   = eop_q;
        reg_rdata_o[SB_PERR]  = perr_q;
        reg_rdata_o[SB_WPERR] = wperr_q;
      end
      REG_ADDR: reg_rdata_o[AW-1:0] = addr_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign fl_addr_o  = busy ? op_addr_q : fw_addr_i;
  assign fl_wdata_o = op_data_q;
  assign fl_prog_o  = done_prog;
  assign fl_erase_o = done_erase;

  p_strobe_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_prog_o || fl_erase_o) |-> busy);
  p_one_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_prog_o && fl_erase_o));
  p_eop_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_prog_o || fl_erase_o) |=> eop_q);
  p_launch_unlocked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(unlocked));
  p_no_prot_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_prog_o || fl_erase_o) |-> !wp_mask_i[fl_addr_o[AW-1:PAGE_BITS]]);
  p_ctrl_hold_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && ctrl_we) |=> ($stable(prog_en_q) && $stable(erase_en_q)));
endmodule

// File: tb/flpe_ctrl_tb.sv
module flpe_ctrl_tb;
  localparam int PROG_CYCLES = 5, ERASE_CYCLES = 12;
  localparam int NUM_PAGES = 8, PAGE_UNITS = 16, DW = 16, AW = 7, DEPTH = 128;
  localparam logic [31:0] KA = 32'hC0DE_1A2B, KB = 32'h5EED_F00D;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NUM_PAGES-1:0] wp_mask = 8'b0000_1000;
  logic reg_we = 1'b0, fw_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [AW-1:0] fw_addr = '0, fl_addr;
  logic [DW-1:0] fw_data = '0, fl_wdata, fl_rdata;
  logic fl_prog, fl_erase;
  logic [DW-1:0] mem [DEPTH];

  int checks = 0, errors = 0;
  logic        exp_kind[$];
  logic [AW-1:0] exp_addr[$];
  logic [DW-1:0] exp_data[$];

  always #2.5 clk = ~clk;

  flpe_ctrl #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_dut (
    .clk_i(clk), .rst_ni, .wp_mask_i(wp_mask), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .fw_we_i(fw_we), .fw_addr_i(fw_addr),
    .fw_data_i(fw_data), .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rdata),
    .fl_prog_o(fl_prog), .fl_erase_o(fl_erase)
  );

  assign fl_rdata = mem[fl_addr];

  initial for (int i = 0; i < DEPTH; i++) mem[i] = '1;

  always @(posedge clk) begin
    if (fl_prog) mem[fl_addr] <= fl_wdata;
    if (fl_erase)
      for (int i = 0; i < PAGE_UNITS; i++) mem[{fl_addr[AW-1:4], 4'(i)}] <= '1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match the oldest expected operation
  always @(negedge clk) begin
    if (rst_ni && (fl_prog || fl_erase)) begin
      checks++;
      if (exp_kind.size() == 0) begin
        errors++;
        $display("FAIL R8/R10/R12 unexpected strobe actual=%h expected=none", fl_addr);
      end else begin
        logic k; logic [AW-1:0] a; logic [DW-1:0] d;
        k = exp_kind.pop_front(); a = exp_addr.pop_front(); d = exp_data.pop_front();
        if (fl_erase !== k || fl_addr !== a || (!k && fl_wdata !== d)) begin
          errors++;
          $display("FAIL R7/R9 strobe actual=%0b/%h/%h expected=%0b/%h/%h",
                   fl_erase, fl_addr, fl_wdata, k, a, d);
        end
      end
    end
  end

  task automatic expect_op(input logic k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_kind.push_back(k); exp_addr.push_back(a); exp_data.push_back(d);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic fw_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); fw_we = 1'b1; fw_addr = a; fw_data = d;
    @(negedge clk); fw_we = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0; reg_addr = 2'd2; #1;
    while (reg_rdata[0]) begin n++; @(negedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; repeat (3) @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic unlock();
    reg_wr(2'd0, KA); reg_wr(2'd0, KB);
  endtask

  initial begin : main
    logic [31:0] r; int n;
    do_reset();
    reg_rd(2'd1, r); chk("R1 ctrl after reset", r, 32'h80);
    reg_rd(2'd2, r); chk("R1 status after reset", r, 32'h0);

    reg_wr(2'd1, 32'h1); reg_rd(2'd1, r); chk("R2 ctrl write while locked", r, 32'h80);
    fw_wr(7'd9, 16'h0BAD); reg_rd(2'd2, r); chk("R8 data write while locked", r, 32'h0);

    unlock(); reg_rd(2'd1, r); chk("R2 unlocked", r, 32'h0);
    reg_wr(2'd1, 32'h1); reg_rd(2'd1, r); chk("R2 prog enable", r, 32'h1);

    expect_op(1'b0, 7'd5, 16'h1234);
    fw_wr(7'd5, 16'h1234); busy_len(n); chk("R5 program busy length", n, PROG_CYCLES);
    reg_rd(2'd2, r); chk("R6 eop after program", r, 32'h2);
    chk("R7 array content", mem[5], 16'h1234);

    reg_wr(2'd2, 32'h0); reg_rd(2'd2, r); chk("R6 zero write keeps eop", r, 32'h2);
    reg_wr(2'd2, 32'h2); reg_rd(2'd2, r); chk("R6 w1c clears eop", r, 32'h0);

    expect_op(1'b0, 7'd6, 16'h5555);
    fw_wr(7'd6, 16'h5555);
    reg_wr(2'd1, 32'h80); fw_wr(7'd8, 16'h1111);
    busy_len(n);
    reg_rd(2'd1, r); chk("R12 ctrl write during busy", r, 32'h1);
    chk("R12 data write during busy", mem[8], 16'hFFFF);
    reg_wr(2'd2, 32'hE);

    fw_wr(7'd5, 16'hABCD); reg_rd(2'd2, r); chk("R11 program error", r, 32'h4);
    chk("R11 array unchanged", mem[5], 16'h1234);
    reg_wr(2'd2, 32'h4);
    expect_op(1'b0, 7'd5, 16'h0000);
    fw_wr(7'd5, 16'h0000); busy_len(n); chk("R11 zero program done", mem[5], 16'h0000);
    reg_wr(2'd2, 32'h2);

    fw_wr(7'd50, 16'h7777); reg_rd(2'd2, r); chk("R10 program wp error", r, 32'h8);
    chk("R10 protected unchanged", mem[50], 16'hFFFF);
    reg_wr(2'd2, 32'h8); reg_rd(2'd2, r); chk("R6 w1c clears wperr", r, 32'h0);

    reg_wr(2'd1, 32'h0); fw_wr(7'd7, 16'h0001);
    reg_rd(2'd2, r); chk("R8 prog disabled no busy", r, 32'h0);
    chk("R8 prog disabled array", mem[7], 16'hFFFF);

    reg_wr(2'd1, 32'h2); reg_wr(2'd1, 32'h6);
    reg_rd(2'd2, r); chk("R9 start without address ignored", r, 32'h0);
    reg_wr(2'd3, 32'd5);
    reg_rd(2'd3, r); chk("R9 address register", r, 32'd5);
    expect_op(1'b1, 7'd0, 16'hFFFF);
    reg_wr(2'd1, 32'h6); busy_len(n); chk("R5 erase busy length", n, ERASE_CYCLES);
    chk("R9 erased unit 5", mem[5], 16'hFFFF);
    chk("R9 erased unit 6", mem[6], 16'hFFFF);
    reg_rd(2'd2, r); chk("R6 eop after erase", r, 32'h2);
    reg_wr(2'd2, 32'h2);

    mem[52] = 16'h00AA;
    reg_wr(2'd3, 32'd50); reg_wr(2'd1, 32'h6);
    reg_rd(2'd2, r); chk("R10 erase wp error", r, 32'h8);
    chk("R10 protected page kept", mem[52], 16'h00AA);

    reg_wr(2'd1, 32'h80); reg_rd(2'd1, r); chk("R4 relocked", r, 32'h80);
    reg_wr(2'd1, 32'h1); reg_rd(2'd1, r); chk("R4 ctrl ignored after relock", r, 32'h80);
    unlock(); reg_rd(2'd1, r); chk("R4 fresh keys reopen", r, 32'h0);

    reg_wr(2'd1, 32'h80);
    reg_wr(2'd0, KA); reg_wr(2'd0, 32'h1234_5678); unlock();
    reg_rd(2'd1, r); chk("R3 wrong second key", r, 32'h80);

    do_reset();
    reg_wr(2'd0, KB); unlock();
    reg_rd(2'd1, r); chk("R3 wrong first key", r, 32'h80);

    repeat (3) @(negedge clk);
    chk("R7/R9 all expected strobes seen", exp_kind.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule